// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

The block is a single-channel serial master. It takes bytes from a valid/ready
transmit port and shifts them out most significant bit first on a generated
serial clock that idles low. It samples the incoming data line on every rising
clock edge and returns each received byte with a one-cycle valid pulse. Data
changes on falling edges. A chip-select line frames each burst. Bytes offered
at the exact end of a frame continue the burst without releasing chip-select.

A single configuration word is written through a simple write strobe. It holds
the following fields:
- three pad-style bits: bit 0 for data out, bit 1 for serial clock, bit 2 for chip-select. 0 selects push-pull and 1 selects open-drain emulation.
- bit 3, transmit-end timing.
- bit 4, chip-select guard length.
- bit 5, data-output gating.
- bit 6, transmit enable.
- bits above bit 6, the half-period divider value `H`. One half period of the serial clock lasts `H+1` system clocks.

All fields reset to 0. Each pin leaves the block as a value and an output-enable
pair. The pad and its pull-up turn that pair into the line level.

Top module: `spi_mstr_engine`

## Requirements
- R1: After reset, and after a reset applied in mid-frame, the outputs are as follows: `tx_ready`=0, chip-select driven high (`cs_oe`=1, `cs_o`=1), serial clock driven low (`sclk_oe`=1, `sclk_o`=0), and data out driven high (`sdo_oe`=1, `sdo_o`=1).
- R2: For each pin, a style bit of 0 drives `oe`=1 and `o`=value. A style bit of 1 gives `o`=0 always, with `oe`=1 for a low value and `oe`=0 (released) for a high value.
- R3: Each frame is 8 bits, MSB first. The serial clock idles low. Data out changes on falling edges, and the byte sent equals the byte accepted. The data-in line is sampled on rising edges, and `rx_data` equals the byte the far side presented.
- R4: Every serial clock half period lasts exactly `H+1` system clocks.
- R5: Let `L` be 1 when config bit 4 is 0 and 3 when it is 1. The time from chip-select falling to the first rising clock edge is `L*(H+1)` system clocks. The time from the last falling edge of a burst to chip-select rising is also `L*(H+1)` system clocks.
- R6: With config bit 3 = 1, the one-cycle `tx_end` pulse coincides with `rx_valid`. With bit 3 = 0, it comes `H+1` clocks earlier, on the final rising edge.
- R7: `rx_valid` is a single-cycle pulse. It appears in the same cycle as the final falling clock edge of the frame.
- R8: `tx_ready` is low while chip-select is active, except in the single cycle that completes a frame. A byte accepted in that cycle continues with chip-select held low and no lead or lag delay. Its first rising edge follows the previous frame's last falling edge by one half period.
- R9: With config bit 5 = 1, data out is released (`sdo_oe`=0) whenever chip-select is high. With bit 5 = 0, an idle push-pull data out is driven high.
- R10: With config bit 6 = 0, `tx_ready` stays 0 and an offered byte never starts a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7+DIV_W | Configuration word (flags in bits 6:0, divider above) |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | DATA_W | Transmit byte |
| tx_ready | output | 1 | Transmit byte accepted when high with `tx_valid` |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle pulse marking a new `rx_data` |
| tx_end | output | 1 | One-cycle transmit-end pulse |
| sdi | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock pad value |
| sclk_oe | output | 1 | Serial clock pad enable |
| cs_o | output | 1 | Chip-select pad value (active low) |
| cs_oe | output | 1 | Chip-select pad enable |
| sdo_o | output | 1 | Serial data out pad value |
| sdo_oe | output | 1 | Serial data out pad enable |

## Verification
The bench keeps the default `DIV_W`=8 and `DATA_W`=8. It reaches different timings by writing divider values 0 through 3 into the configuration word. The divider value 0 gives one-clock half periods. In that case the lead, lag, transmit-end offset and back-to-back gap all fall on neighbouring cycles, so any counting error shows up as an off-by-one. The larger divider values separate the short and long guard lengths and the early and late transmit-end pulse by several clocks. One table row turns on open-drain emulation on all three pins, and the bench resolves each line through a modelled pull-up.

// File: rtl/spi_pkg.sv
package spi_pkg;

  // configuration flag positions (the divider field sits above them)
  localparam int CF_DOUT_OD   = 0;
  localparam int CF_SCLK_OD   = 1;
  localparam int CF_CS_OD     = 2;
  localparam int CF_TEND_LATE = 3;
  localparam int CF_CS_LONG   = 4;
  localparam int CF_DOUT_GATE = 5;
  localparam int CF_TX_EN     = 6;
  localparam int CF_FLAGS     = 7;

  // pin indices, matching the style-bit positions
  localparam int PIN_SDO  = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_CS   = 2;
  localparam int PIN_N    = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_LAG   = 2'd3
  } eng_st_e;

  // returns {oe, o} for a logical pin value under a drive style
  function automatic logic [1:0] pad_drive(input logic od, input logic val);
    return od ? {~val, 1'b0} : {1'b1, val};
  endfunction

  // extra guard ticks counted by the lead/lag counter beyond the first half
  function automatic logic [1:0] guard_extra(input logic long_sel);
    return long_sel ? 2'd2 : 2'd0;
  endfunction

endpackage

// File: rtl/spi_half_div.sv
module spi_half_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_pad_cell.sv
module spi_pad_cell import spi_pkg::*; (
  input  logic od,
  input  logic val,
  input  logic rel,
  output logic o,
  output logic oe
);
  logic [1:0] drv;

  always_comb begin
    drv = rel ? 2'b00 : pad_drive(od, val);
    oe  = drv[1];
    o   = drv[0];
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core import spi_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tx_en,
  input  logic              cs_long,
  input  logic              tend_late,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              sdi,
  output eng_st_e           st,
  output logic              cs_n,
  output logic              sclk,
  output logic              sdo_bit,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              tx_end,
  output logic              last_rise,
  output logic              frame_end
);
  localparam int HALVES = 2 * DATA_W;
  localparam int HC_W   = $clog2(HALVES);
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALVES - 1);
  localparam logic [HC_W-1:0] HC_LRISE = HC_W'(HALVES - 2);

  logic [DATA_W-1:0] txsh_q, rxsh_q;
  logic [HC_W-1:0]   hc_q;
  logic [1:0]        gcnt_q;
  logic              accept;

  assign frame_end = (st == ST_SHIFT) && tick && (hc_q == HC_LAST);
  assign last_rise = (st == ST_SHIFT) && tick && (hc_q == HC_LRISE);
  assign tx_ready  = tx_en && ((st == ST_IDLE) || frame_end);
  assign accept    = tx_valid && tx_ready;
  assign sdo_bit   = (st == ST_IDLE) ? 1'b1 : txsh_q[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      txsh_q   <= '0;
      rxsh_q   <= '0;
      hc_q     <= '0;
      gcnt_q   <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      tx_end   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_end   <= tend_late ? frame_end : last_rise;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            txsh_q <= tx_data;
            cs_n   <= 1'b0;
            hc_q   <= '0;
            gcnt_q <= guard_extra(cs_long);
            st     <= cs_long ? ST_LEAD : ST_SHIFT;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            if (gcnt_q == 2'd1) st <= ST_SHIFT;
            gcnt_q <= gcnt_q - 2'd1;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!hc_q[0]) begin
              sclk   <= 1'b1;
              rxsh_q <= {rxsh_q[DATA_W-2:0], sdi};
              hc_q   <= hc_q + 1'b1;
            end else begin
              sclk <= 1'b0;
              if (hc_q == HC_LAST) begin
                rx_data  <= rxsh_q;
                rx_valid <= 1'b1;
                if (accept) begin
                  txsh_q <= tx_data;
                  hc_q   <= '0;
                end else begin
                  gcnt_q <= guard_extra(cs_long);
                  st     <= ST_LAG;
                end
              end else begin
                txsh_q <= {txsh_q[DATA_W-2:0], 1'b0};
                hc_q   <= hc_q + 1'b1;
              end
            end
          end
        end
        ST_LAG: begin
          if (tick) begin
            if (gcnt_q == 2'd0) begin
              cs_n <= 1'b1;
              st   <= ST_IDLE;
            end else begin
              gcnt_q <= gcnt_q - 2'd1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_mstr_engine.sv
module spi_mstr_engine import spi_pkg::*; #(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CF_FLAGS+DIV_W-1:0] cfg_wdata,
  input  logic                      tx_valid,
  input  logic [DATA_W-1:0]         tx_data,
  output logic                      tx_ready,
  output logic [DATA_W-1:0]         rx_data,
  output logic                      rx_valid,
  output logic                      tx_end,
  input  logic                      sdi,
  output logic                      sclk_o,
  output logic                      sclk_oe,
  output logic                      cs_o,
  output logic                      cs_oe,
  output logic                      sdo_o,
  output logic                      sdo_oe
);
  localparam int CFG_W = CF_FLAGS + DIV_W;

  logic [CFG_W-1:0] cfg_q;
  logic [DIV_W-1:0] half_div;
  eng_st_e          st;
  logic             tick, cs_n, sclk, sdo_bit, last_rise, frame_end;
  logic [PIN_N-1:0] pin_val, pin_od, pin_rel, pin_o, pin_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  assign half_div = cfg_q[CFG_W-1:CF_FLAGS];

  spi_half_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (st != ST_IDLE),
    .half_div (half_div),
    .tick     (tick)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .tx_en     (cfg_q[CF_TX_EN]),
    .cs_long   (cfg_q[CF_CS_LONG]),
    .tend_late (cfg_q[CF_TEND_LATE]),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .sdi       (sdi),
    .st        (st),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sdo_bit   (sdo_bit),
    .tx_ready  (tx_ready),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .tx_end    (tx_end),
    .last_rise (last_rise),
    .frame_end (frame_end)
  );

  assign pin_val[PIN_SDO]  = sdo_bit;
  assign pin_val[PIN_SCLK] = sclk;
  assign pin_val[PIN_CS]   = cs_n;
  assign pin_rel[PIN_SDO]  = cfg_q[CF_DOUT_GATE] && cs_n;
  assign pin_rel[PIN_SCLK] = 1'b0;
  assign pin_rel[PIN_CS]   = 1'b0;
  assign pin_od            = cfg_q[PIN_N-1:0];

  for (genvar p = 0; p < PIN_N; p++) begin : g_pad
    spi_pad_cell u_pad (
      .od  (pin_od[p]),
      .val (pin_val[p]),
      .rel (pin_rel[p]),
      .o   (pin_o[p]),
      .oe  (pin_oe[p])
    );
  end

  assign sdo_o   = pin_o[PIN_SDO];
  assign sdo_oe  = pin_oe[PIN_SDO];
  assign sclk_o  = pin_o[PIN_SCLK];
  assign sclk_oe = pin_oe[PIN_SCLK];
  assign cs_o    = pin_o[PIN_CS];
  assign cs_oe   = pin_oe[PIN_CS];
endmodule

// File: rtl/spi_mstr_chk.sv
module spi_mstr_chk import spi_pkg::*; (
  input logic                clk,
  input logic                rst_n,
  input logic [CF_FLAGS-1:0] flags,
  input logic                tick,
  input logic                sclk,
  input logic                cs_n,
  input logic                frame_end,
  input logic                rx_valid,
  input logic                tx_ready,
  input logic                sdo_o,
  input logic                sdo_oe,
  input logic                sclk_o,
  input logic                cs_o
);
  AST_OD_SDO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    flags[CF_DOUT_OD] |-> !sdo_o); // R2
  AST_OD_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    flags[CF_SCLK_OD] |-> !sclk_o); // R2
  AST_OD_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    flags[CF_CS_OD] |-> !cs_o); // R2
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R3
  AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sclk)); // R4
  AST_RXV_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> rx_valid); // R7
  AST_RXV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R7
  AST_READY_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && tx_ready) |-> frame_end); // R8
  AST_GATE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[CF_DOUT_GATE] && cs_n) |-> !sdo_oe); // R9
  AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> flags[CF_TX_EN]); // R10
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !flags[CF_TX_EN]) |=> cs_n); // R10
endmodule

bind spi_mstr_engine spi_mstr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flags     (cfg_q[spi_pkg::CF_FLAGS-1:0]),
  .tick      (tick),
  .sclk      (sclk),
  .cs_n      (cs_n),
  .frame_end (frame_end),
  .rx_valid  (rx_valid),
  .tx_ready  (tx_ready),
  .sdo_o     (sdo_o),
  .sdo_oe    (sdo_oe),
  .sclk_o    (sclk_o),
  .cs_o      (cs_o)
);

// File: tb/tb_spi_mstr_engine.sv
`timescale 1ns/1ps
module tb_spi_mstr_engine;
  localparam int DIV_W = 8;
  localparam int NVEC  = 6;
  // {flags[6:0], half_div[7:0], byte0, byte1, count[1:0]}
  localparam logic [32:0] VEC [NVEC] = '{
    {7'h40, 8'd0, 8'hA5, 8'h00, 2'd1},
    {7'h48, 8'd1, 8'h3C, 8'h00, 2'd1},
    {7'h50, 8'd2, 8'h81, 8'h00, 2'd1},
    {7'h58, 8'd0, 8'hFF, 8'h00, 2'd2},
    {7'h60, 8'd3, 8'h5A, 8'hC3, 2'd2},
    {7'h47, 8'd1, 8'h96, 8'h00, 2'd1}
  };

  logic clk = 0, rst_n = 0, cfg_we = 0, tx_valid = 0, sdi = 1;
  logic [14:0] cfg_wdata = '0;
  logic [7:0]  tx_data = '0;
  logic tx_ready, rx_valid, tx_end, sclk_o, sclk_oe, cs_o, cs_oe, sdo_o, sdo_oe;
  logic [7:0] rx_data;

  always #5 clk = ~clk;

  spi_mstr_engine #(.DIV_W(DIV_W), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .tx_end(tx_end), .sdi(sdi),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .cs_o(cs_o), .cs_oe(cs_oe),
    .sdo_o(sdo_o), .sdo_oe(sdo_oe)
  );

  // pad lines with pull-ups
  wire cs_l   = cs_oe   ? cs_o   : 1'b1;
  wire sclk_l = sclk_oe ? sclk_o : 1'b1;
  wire sdo_l  = sdo_oe  ? sdo_o  : 1'b1;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k);
    logic [7:0] m = 8'(k * 8'h3B);
    return 8'hA5 ^ m;
  endfunction

  // expectations for the running vector
  int d_exp = 1, g_exp = 1;
  bit late = 0, gate = 0, mon_en = 0;
  logic [2:0] odm = '0;
  logic [7:0] sent [16];
  int sent_n = 0;

  // monitor and far-side model
  int cyc = 0, t_cs_fall = 0, t_edge = 0, t_fall = 0, t_tend = 0;
  int sbit = 0, frame_no = 0, rxidx = 0, txidx = 0, ccnt = 0, cs_rises = 0;
  int bad_half = 0, bad_rdy = 0, bad_gate = 0, bad_od = 0;
  bit first_rise = 0, rdy_pend = 0, prev_cs = 1, prev_sclk = 0;
  logic [7:0] cap = '0, cur;

  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (tx_end) t_tend = cyc;
      if (prev_cs && !cs_l) begin
        t_cs_fall = cyc; first_rise = 1; sbit = 0; t_edge = cyc;
        cur = pat(frame_no); sdi <= cur[7];
      end
      if (!prev_sclk && sclk_l) begin
        if (first_rise) begin
          chk("R5 lead", cyc - t_cs_fall, g_exp * d_exp);
          first_rise = 0;
        end else if (cyc - t_edge != d_exp) bad_half++;
        t_edge = cyc;
        cap = {cap[6:0], sdo_l};
        ccnt++;
        if (ccnt == 8) begin
          chk("R3 transmitted byte", cap, sent[txidx]);
          txidx++; ccnt = 0;
        end
      end
      if (prev_sclk && !sclk_l) begin
        if (cyc - t_edge != d_exp) bad_half++;
        t_edge = cyc; t_fall = cyc; sbit++;
        if (sbit == 8) begin
          chk("R7 rx_valid with last fall", rx_valid, 1);
          frame_no++; sbit = 0;
        end
        cur = pat(frame_no); sdi <= cur[3'(7 - sbit)];
      end
      if (!prev_cs && cs_l) begin
        chk("R5 lag", cyc - t_fall, g_exp * d_exp);
        cs_rises++;
      end
      if (rx_valid) begin
        chk("R3 received byte", rx_data, pat(rxidx));
        rxidx++;
        chk("R6 tend offset", cyc - t_tend, late ? 0 : d_exp);
      end
      if (rdy_pend && !(prev_sclk && !sclk_l)) bad_rdy++;
      rdy_pend = !cs_l && tx_ready;
      if (gate && cs_l && sdo_oe) bad_gate++;
      if ((odm[0] && sdo_o) || (odm[1] && sclk_o) || (odm[2] && cs_o)) bad_od++;
    end
    prev_cs = cs_l; prev_sclk = sclk_l;
  end

  task automatic write_cfg(input logic [6:0] f, input logic [7:0] hd);
    @(negedge clk);
    cfg_wdata = {hd, f}; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    sent[sent_n] = b; sent_n++;
    @(negedge clk);
    tx_valid = 1; tx_data = b;
    while (!tx_ready) @(negedge clk);
    @(posedge clk); #1;
    tx_valid = 0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tx_ready", tx_ready, 0);
    chk("R1 cs pad", {cs_oe, cs_o}, 2'b11);
    chk("R1 sclk pad", {sclk_oe, sclk_o}, 2'b10);
    chk("R1 sdo pad", {sdo_oe, sdo_o}, 2'b11);
    rst_n = 1;
    @(negedge clk);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [6:0] f  = VEC[v][32:26];
      logic [7:0] hd = VEC[v][25:18];
      int cnt        = int'(VEC[v][1:0]);
      write_cfg(f, hd);
      d_exp = int'(hd) + 1; g_exp = f[4] ? 3 : 1;
      late = f[3]; gate = f[5]; odm = f[2:0];
      bad_half = 0; bad_rdy = 0; bad_gate = 0; bad_od = 0; cs_rises = 0;
      mon_en = 1;
      send_byte(VEC[v][17:10]);
      if (cnt == 2) send_byte(VEC[v][9:2]);
      repeat (40 * d_exp + 10) @(negedge clk);
      chk("R3 frames sent", txidx, sent_n);
      chk("R3 frames received", rxidx, sent_n);
      chk("R4 half period", bad_half, 0);
      chk("R8 ready low in frame", bad_rdy, 0);
      chk("R8 one burst", cs_rises, 1);
      chk("R9 gated release", bad_gate, 0);
      chk("R2 open drain low only", bad_od, 0);
      mon_en = 0;
    end

    // R2 idle open-drain encoding
    write_cfg(7'h47, 8'd1);
    @(negedge clk);
    chk("R2 cs released", {cs_oe, cs_o}, 2'b00);
    chk("R2 sclk pulls low", {sclk_oe, sclk_o}, 2'b10);
    chk("R2 sdo released", {sdo_oe, sdo_o}, 2'b00);

    // R9 gating in push-pull idle
    write_cfg(7'h60, 8'd0);
    @(negedge clk);
    chk("R9 gated idle sdo", sdo_oe, 0);
    write_cfg(7'h40, 8'd0);
    @(negedge clk);
    chk("R9 ungated idle sdo", {sdo_oe, sdo_o}, 2'b11);

    // R10 transmit disabled
    write_cfg(7'h00, 8'd0);
    tx_valid = 1; tx_data = 8'h77;
    begin
      int seen_rdy = 0, seen_cs = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (tx_ready) seen_rdy++;
        if (cs_l == 0) seen_cs++;
      end
      chk("R10 ready stays low", seen_rdy, 0);
      chk("R10 no frame start", seen_cs, 0);
    end
    tx_valid = 0;

    // R1 reset in mid-frame
    write_cfg(7'h40, 8'd2);
    @(negedge clk);
    tx_valid = 1; tx_data = 8'h0F;
    @(negedge clk);
    tx_valid = 0;
    repeat (10) @(negedge clk);
    chk("R1 frame running before reset", cs_l, 0);
    rst_n = 0;
    @(negedge clk);
    chk("R1 mid-frame reset cs", {cs_oe, cs_o}, 2'b11);
    chk("R1 mid-frame reset sclk", {sclk_oe, sclk_o}, 2'b10);
    chk("R1 mid-frame reset sdo", {sdo_oe, sdo_o}, 2'b11);
    chk("R1 mid-frame reset ready", tx_ready, 0);
    rst_n = 1;
    @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule